// File: doc/BRIEF.md
# Serial Link Command Channel Controller

This block is the initiator end of a point-to-point serial link that carries single-value register accesses. It has four independent command channels. Each channel takes one request at a time: a write or a read of 8, 16 or 32 bits at a full 32-bit target address. The channel turns the request into a command frame. The frame carries a rolling 3-bit transfer ID and a CRC16. It is offered to a lower-layer serializer. The channel then waits for the matching answer: an acknowledge for a write, or a read-response frame carrying the data for a read. A per-channel cycle budget catches answers that never arrive. Each outcome is signalled by a one-cycle interrupt pulse.

Both frame streams use valid/ready. On the transmit side, once `tx_valid` rises it stays high and `tx_data` stays unchanged until a cycle with `tx_ready` high. A request input is taken on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` stays low while the channel holds a request. The receive side never applies back-pressure, so `rx_ready` is constantly high and every `rx_valid` cycle delivers one response frame. Timeout values are plain control inputs, read live in every cycle.

Command frame, 96 bits, most significant bit first:

| Bits | Content |
|------|---------|
| [95:80] | header |
| [79:48] | address |
| [47:16] | data |
| [15:0] | CRC |

Command header:

| Bits | Content |
|------|---------|
| [15:14] | channel |
| [13:11] | ID |
| [10:9] | kind |
| [8:7] | size |
| [6:0] | zero |

Response frame, 64 bits:

| Bits | Content |
|------|---------|
| [63:48] | header, same layout as the command header |
| [47:16] | data |
| [15:0] | CRC |

Kind codes are write command 0, read command 1, acknowledge 2 and read response 3. Size codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.

Top module: `slink_cmd_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, `req_ready` is all ones, `tx_valid` is 0, every interrupt output is 0 and `rd_data` is 0.
- R2: `req_ready[c]` is high exactly when channel c holds no request. A request is captured at an edge where `req_valid[c]` and `req_ready[c]` are both high, and `req_ready[c]` then stays low until that request is finished.
- R3: The command frame is laid out as follows. Header bits [15:14] hold the channel number, [13:11] the ID, [10:9] the kind (0 for a write, 1 for a read), [8:7] the size code, and [6:0] are zero. Bits [79:48] hold the address. Bits [47:16] hold the write data masked to its size (code 0 keeps the low 8 bits, code 1 the low 16 bits, codes 2 and 3 all 32 bits); for a read they are zero.
- R4: Frame bits [15:0] hold a CRC16 over the bits above them, taken from the most significant bit down. The CRC uses polynomial 0x1021, a start value of 0xFFFF, no reflection and no final inversion. The same rule applies to response frames, over bits [63:16].
- R5: Once `tx_valid` is high with `tx_ready` low, in the next cycle `tx_valid` is still high and `tx_data` is unchanged.
- R6: When several channels have frames waiting to be sent, the lowest channel number is offered. A frame that has been offered but not yet accepted keeps the port, even if a lower channel becomes ready.
- R7: Each channel has its own 3-bit ID. It is 0 after reset, is used in that channel's next frame, and increments by one, wrapping modulo 8, at every edge where a frame from that channel is accepted.
- R8: A response is good for channel c when all of the following hold: its CRC is correct, its header channel is c, its ID equals the ID of the frame c last sent, its kind is 2 for a write or 3 for a read, its header bits [8:0] are zero, and c is waiting for an answer. A good response frees the channel. In the next cycle `irq_done[c]` pulses. For a read, `irq_rdv[c]` also pulses and `rd_data[c]` shows the response data masked to the request size; `rd_data[c]` then holds that value until the next read on c completes.
- R9: A response that names channel c but is not good pulses `irq_err[c]` in the next cycle and leaves channel c's state unchanged.
- R10: Let T be the channel's `cfg_timeout` value, with T > 0. If a frame is accepted at edge k and no good response arrives at edges k+1 through k+T, the channel is freed at edge k+T and `irq_tmo[c]` pulses in the next cycle. A good response at edge k+T still completes the request normally. T = 0 disables the timeout.
- R11: `irq_any` is the OR of all channel interrupt pulses in the same cycle, and `rx_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 4 | Per-channel request valid |
| req_ready | output | 4 | Per-channel request ready (channel free) |
| req_write | input | 4 | Per-channel request direction, 1 = write |
| req_size | input | 8 | Per-channel 2-bit size code |
| req_addr | input | 128 | Per-channel 32-bit target address |
| req_wdata | input | 128 | Per-channel 32-bit write data |
| cfg_timeout | input | 64 | Per-channel 16-bit timeout in cycles, 0 = off |
| tx_valid | output | 1 | Command frame valid |
| tx_ready | input | 1 | Serializer accepts frame |
| tx_data | output | 96 | Command frame |
| rx_valid | input | 1 | Response frame valid |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 64 | Response frame |
| rd_data | output | 128 | Per-channel last read data |
| irq_done | output | 4 | Per-channel request completed pulse |
| irq_rdv | output | 4 | Per-channel read data valid pulse |
| irq_tmo | output | 4 | Per-channel timeout pulse |
| irq_err | output | 4 | Per-channel bad response pulse |
| irq_any | output | 1 | OR of all interrupt pulses |

## Verification
The bench holds the serializer back while a lower channel becomes ready behind an offered frame. A design that re-arbitrates mid-offer would change `tx_data` under a stalled `tx_valid`. It runs one channel through nine transfers to cross the ID wrap, so an ID counter that stops or skips would send a wrong frame. It places one answer exactly on the last cycle of the timeout budget and another one cycle late, catching an off-by-one that either times out too early or completes after the timeout. Responses with a corrupted CRC, a stale ID, the wrong kind, or no waiting channel must each raise an error without completing, so a design that completes on a header match alone would pulse `irq_done` where only `irq_err` belongs.

// File: rtl/slk_pkg.sv
package slk_pkg;
  localparam int CH_W   = 2;
  localparam int ID_W   = 3;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int HDR_W  = 16;
  localparam int CRC_W  = 16;
  localparam int CMD_W  = HDR_W + ADDR_W + DATA_W + CRC_W;
  localparam int RSP_W  = HDR_W + DATA_W + CRC_W;
  localparam int CMD_BODY_W = CMD_W - CRC_W;
  localparam int RSP_BODY_W = RSP_W - CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {K_WR = 2'd0, K_RD = 2'd1, K_ACK = 2'd2, K_RDR = 2'd3} kind_e;
  typedef enum logic [1:0] {CH_IDLE = 2'd0, CH_PEND = 2'd1, CH_WAIT = 2'd2} ch_state_e;

  // Bit-serial CRC, most significant bit first, over the low nbits of d.
  function automatic logic [CRC_W-1:0] crc16(input logic [CMD_BODY_W-1:0] d, input int nbits);
    logic [CRC_W-1:0] c;
    logic fb;
    c = CRC_INIT;
    for (int i = CMD_BODY_W - 1; i >= 0; i--) begin
      if (i < nbits) begin
        fb = c[CRC_W-1] ^ d[i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return DATA_W'(32'h0000_00FF);
      2'd1:    return DATA_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/slk_arbiter.sv
module slk_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  input  logic              tx_ready,
  output logic [NUM_CH-1:0] gnt,
  output logic              tx_valid
);
  logic              lock_q;
  logic [NUM_CH-1:0] lock_gnt_q;
  logic [NUM_CH-1:0] pick;

  // Lowest index wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) pick = NUM_CH'(1) << i;
    end
  end

  assign gnt      = lock_q ? lock_gnt_q : pick;
  assign tx_valid = |gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_gnt_q <= '0;
    end else begin
      lock_q     <= tx_valid && !tx_ready;
      lock_gnt_q <= gnt;
    end
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(gnt)));
endmodule

// File: rtl/slk_rsp_check.sv
module slk_rsp_check import slk_pkg::*; #(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [RSP_W-1:0]       rx_data,
  input  logic [NUM_CH-1:0]      waiting,
  input  logic [NUM_CH-1:0]      is_write,
  input  logic [NUM_CH*ID_W-1:0] sent_id,
  output logic [NUM_CH-1:0]      rsp_ok,
  output logic [NUM_CH-1:0]      rsp_bad,
  output logic [DATA_W-1:0]      rsp_data
);
  logic [HDR_W-1:0] hdr;
  logic [CH_W-1:0]  hdr_ch;
  logic [ID_W-1:0]  hdr_id;
  logic [1:0]       hdr_kind;
  logic             hdr_clean;
  logic             crc_ok;

  assign hdr       = rx_data[RSP_W-1 -: HDR_W];
  assign hdr_ch    = hdr[HDR_W-1 -: CH_W];
  assign hdr_id    = hdr[HDR_W-1-CH_W -: ID_W];
  assign hdr_kind  = hdr[HDR_W-1-CH_W-ID_W -: 2];
  assign hdr_clean = (hdr[HDR_W-CH_W-ID_W-3:0] == '0);
  assign rsp_data  = rx_data[CRC_W +: DATA_W];
  assign crc_ok    = crc16(CMD_BODY_W'(rx_data[RSP_W-1:CRC_W]), RSP_BODY_W) == rx_data[CRC_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel, good;
    assign sel  = rx_valid && (hdr_ch == CH_W'(c));
    assign good = crc_ok && hdr_clean && waiting[c] &&
                  (hdr_id == sent_id[c*ID_W +: ID_W]) &&
                  (hdr_kind == (is_write[c] ? K_ACK : K_RDR));
    assign rsp_ok[c]  = sel && good;
    assign rsp_bad[c] = sel && !good;
  end

  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_ok | rsp_bad));
endmodule

// File: rtl/slk_channel.sv
module slk_channel import slk_pkg::*; #(
  parameter int CH_IDX = 0,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TMO_W-1:0]  cfg_tmo,
  input  logic              frame_acc,
  output logic              pending,
  output logic [CMD_W-1:0]  frame,
  output logic              waiting,
  output logic              is_write,
  output logic [ID_W-1:0]   sent_id,
  input  logic              rsp_ok,
  input  logic              rsp_bad,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_done,
  output logic              irq_rdv,
  output logic              irq_tmo,
  output logic              irq_err
);
  ch_state_e          st_q;
  logic [1:0]         sz_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [ID_W-1:0]    id_q;
  logic [TMO_W-1:0]   cnt_q;
  logic               tmo_hit;
  logic [HDR_W-1:0]   hdr;
  logic [CMD_BODY_W-1:0] body;

  assign req_ready = (st_q == CH_IDLE);
  assign pending   = (st_q == CH_PEND);
  assign waiting   = (st_q == CH_WAIT);
  assign tmo_hit   = waiting && (cfg_tmo != '0) && ((cnt_q + TMO_W'(1)) == cfg_tmo);

  always_comb begin
    hdr   = {CH_W'(CH_IDX), id_q, (is_write ? K_WR : K_RD), sz_q, 7'b0};
    body  = {hdr, addr_q, (is_write ? (data_q & size_mask(sz_q)) : '0)};
    frame = {body, crc16(body, CMD_BODY_W)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CH_IDLE;
      is_write <= 1'b0;
      sz_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      id_q     <= '0;
      sent_id  <= '0;
      cnt_q    <= '0;
      rd_data  <= '0;
      irq_done <= 1'b0;
      irq_rdv  <= 1'b0;
      irq_tmo  <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_rdv  <= 1'b0;
      irq_tmo  <= 1'b0;
      irq_err  <= rsp_bad;
      case (st_q)
        CH_IDLE: if (req_valid) begin
          is_write <= req_write;
          sz_q     <= req_size;
          addr_q   <= req_addr;
          data_q   <= req_wdata;
          st_q     <= CH_PEND;
        end
        CH_PEND: if (frame_acc) begin
          sent_id <= id_q;
          id_q    <= id_q + ID_W'(1);
          cnt_q   <= '0;
          st_q    <= CH_WAIT;
        end
        CH_WAIT: begin
          if (rsp_ok) begin
            irq_done <= 1'b1;
            if (!is_write) begin
              irq_rdv <= 1'b1;
              rd_data <= rsp_data & size_mask(sz_q);
            end
            st_q <= CH_IDLE;
          end else if (tmo_hit) begin
            irq_tmo <= 1'b1;
            st_q    <= CH_IDLE;
          end else begin
            cnt_q <= cnt_q + TMO_W'(1);
          end
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  // R7
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_acc |=> (sent_id == $past(id_q)) && (id_q == $past(id_q) + ID_W'(1)));

  // R10
  tmo_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tmo) |-> ($past(cfg_tmo) != '0));

  // R8
  done_vs_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_tmo));

  // R2
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
endmodule

// File: rtl/slink_cmd_ctrl.sv
module slink_cmd_ctrl import slk_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int TMO_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        req_valid,
  output logic [NUM_CH-1:0]        req_ready,
  input  logic [NUM_CH-1:0]        req_write,
  input  logic [NUM_CH*2-1:0]      req_size,
  input  logic [NUM_CH*ADDR_W-1:0] req_addr,
  input  logic [NUM_CH*DATA_W-1:0] req_wdata,
  input  logic [NUM_CH*TMO_W-1:0]  cfg_timeout,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [CMD_W-1:0]         tx_data,
  input  logic                     rx_valid,
  output logic                     rx_ready,
  input  logic [RSP_W-1:0]         rx_data,
  output logic [NUM_CH*DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0]        irq_done,
  output logic [NUM_CH-1:0]        irq_rdv,
  output logic [NUM_CH-1:0]        irq_tmo,
  output logic [NUM_CH-1:0]        irq_err,
  output logic                     irq_any
);
  logic [NUM_CH-1:0]      pend, waiting, is_write, gnt, rsp_ok, rsp_bad;
  logic [NUM_CH*ID_W-1:0] sent_id;
  logic [CMD_W-1:0]       frame_w [NUM_CH];
  logic [DATA_W-1:0]      rsp_data;

  assign rx_ready = 1'b1;
  assign irq_any  = |{irq_done, irq_rdv, irq_tmo, irq_err};

  slk_arbiter #(.NUM_CH(NUM_CH)) arb_i (
    .clk(clk), .rst_n(rst_n), .pend(pend), .tx_ready(tx_ready),
    .gnt(gnt), .tx_valid(tx_valid)
  );

  slk_rsp_check #(.NUM_CH(NUM_CH)) rsp_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .waiting(waiting), .is_write(is_write), .sent_id(sent_id),
    .rsp_ok(rsp_ok), .rsp_bad(rsp_bad), .rsp_data(rsp_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    slk_channel #(.CH_IDX(c), .TMO_W(TMO_W)) ch_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[c]), .req_ready(req_ready[c]), .req_write(req_write[c]),
      .req_size(req_size[c*2 +: 2]), .req_addr(req_addr[c*ADDR_W +: ADDR_W]),
      .req_wdata(req_wdata[c*DATA_W +: DATA_W]), .cfg_tmo(cfg_timeout[c*TMO_W +: TMO_W]),
      .frame_acc(gnt[c] && tx_ready), .pending(pend[c]), .frame(frame_w[c]),
      .waiting(waiting[c]), .is_write(is_write[c]), .sent_id(sent_id[c*ID_W +: ID_W]),
      .rsp_ok(rsp_ok[c]), .rsp_bad(rsp_bad[c]), .rsp_data(rsp_data),
      .rd_data(rd_data[c*DATA_W +: DATA_W]),
      .irq_done(irq_done[c]), .irq_rdv(irq_rdv[c]), .irq_tmo(irq_tmo[c]), .irq_err(irq_err[c])
    );
  end

  always_comb begin
    tx_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (gnt[c]) tx_data = tx_data | frame_w[c];
    end
  end

  // R5
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  // R9
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err & irq_done) == '0);
endmodule

// File: tb/slink_cmd_ctrl_tb_top.sv
module slink_cmd_ctrl_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [3:0]   req_valid = '0, req_write = '0, req_ready;
  logic [7:0]   req_size = '0;
  logic [127:0] req_addr = '0, req_wdata = '0, rd_data;
  logic [63:0]  cfg_timeout = {4{16'd40}};
  logic         tx_valid, tx_ready = 1'b1, rx_valid = 1'b0, rx_ready, irq_any;
  logic [95:0]  tx_data;
  logic [63:0]  rx_data = '0;
  logic [3:0]   irq_done, irq_rdv, irq_tmo, irq_err;

  slink_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_timeout(cfg_timeout), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rd_data(rd_data),
    .irq_done(irq_done), .irq_rdv(irq_rdv), .irq_tmo(irq_tmo), .irq_err(irq_err),
    .irq_any(irq_any)
  );

  int nchk = 0, nerr = 0, cyc = 0, tx_mode = 0;
  bit finished = 0;
  bit [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit [15:0] bcrc(bit [79:0] v, int n);
    bit [15:0] c = 16'hFFFF;
    for (int i = n - 1; i >= 0; i--) begin
      bit fb = c[15] ^ v[i];
      c = {c[14:0], 1'b0};
      if (fb) c ^= 16'h1021;
    end
    return c;
  endfunction

  function automatic bit [31:0] msk(bit [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // Behavioural reference model: 0 free, 1 queued for sending, 2 awaiting answer.
  int        m_st[4], m_id[4], m_sid[4], m_cnt[4];
  bit        m_wr[4];
  bit [1:0]  m_sz[4];
  bit [31:0] m_addr[4], m_wd[4], e_rd[4];
  bit [3:0]  e_done, e_rdv, e_tmo, e_err;
  int        e_gnt = -1, m_lock = -1;
  bit        stall_prev = 0;
  bit [95:0] prev_tx;

  function automatic bit [95:0] exp_frame(int c);
    bit [79:0] b;
    b = {c[1:0], m_id[c][2:0], 1'b0, ~m_wr[c], m_sz[c], 7'b0, m_addr[c],
         (m_wr[c] ? (m_wd[c] & msk(m_sz[c])) : 32'h0)};
    return {b, bcrc(b, 80)};
  endfunction

  always @(posedge clk) begin
    cyc++;
    stall_prev = tx_valid && !tx_ready;
    prev_tx    = tx_data;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_st[c] = 0; m_id[c] = 0; m_sid[c] = 0; m_cnt[c] = 0; e_rd[c] = 0;
      end
      e_done = 0; e_rdv = 0; e_tmo = 0; e_err = 0; e_gnt = -1; m_lock = -1;
    end else begin
      int g;
      bit crc_good;
      g = e_gnt;
      crc_good = (bcrc({32'h0, rx_data[63:16]}, 48) == rx_data[15:0]);
      for (int c = 0; c < 4; c++) begin
        bit named, good;
        int tmo;
        named = rx_valid && (rx_data[63:62] == c[1:0]);
        good  = crc_good && (rx_data[56:48] == 0) && m_st[c] == 2 &&
                (rx_data[61:59] == m_sid[c][2:0]) && (rx_data[58:57] == (m_wr[c] ? 2 : 3));
        tmo   = cfg_timeout[c*16 +: 16];
        e_done[c] = 0; e_rdv[c] = 0; e_tmo[c] = 0;
        e_err[c]  = named && !good;
        if (m_st[c] == 0) begin
          if (req_valid[c]) begin
            m_wr[c] = req_write[c]; m_sz[c] = req_size[c*2 +: 2];
            m_addr[c] = req_addr[c*32 +: 32]; m_wd[c] = req_wdata[c*32 +: 32];
            m_st[c] = 1;
          end
        end else if (m_st[c] == 1) begin
          if (g == c && tx_ready) begin
            m_sid[c] = m_id[c]; m_id[c] = (m_id[c] + 1) % 8; m_cnt[c] = 0; m_st[c] = 2;
          end
        end else begin
          if (named && good) begin
            e_done[c] = 1;
            if (!m_wr[c]) begin e_rdv[c] = 1; e_rd[c] = rx_data[47:16] & msk(m_sz[c]); end
            m_st[c] = 0;
          end else if (tmo != 0 && m_cnt[c] + 1 == tmo) begin
            e_tmo[c] = 1; m_st[c] = 0;
          end else m_cnt[c]++;
        end
      end
      m_lock = (g >= 0 && !tx_ready) ? g : -1;
      e_gnt = m_lock;
      if (e_gnt < 0)
        for (int c = 3; c >= 0; c--) if (m_st[c] == 1) e_gnt = c;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cyc >= 1 && !finished) begin
      for (int c = 0; c < 4; c++) begin
        chk("R2 req_ready", req_ready[c], m_st[c] == 0);
        chk("R8 rd_data", rd_data[c*32 +: 32], e_rd[c]);
      end
      chk("R6 tx_valid", tx_valid, e_gnt >= 0);
      if (e_gnt >= 0 && tx_valid) begin
        bit [95:0] ef;
        ef = exp_frame(e_gnt);
        chk("R6 offered channel", tx_data[95:94], ef[95:94]);
        chk("R7 frame id", tx_data[93:91], ef[93:91]);
        chk("R3 frame fields", tx_data[95:16], ef[95:16]);
        chk("R4 frame crc", tx_data[15:0], ef[15:0]);
      end
      if (stall_prev && rst_n) chk("R5 held offer", {tx_valid, tx_data}, {1'b1, prev_tx});
      chk("R8 irq_done", irq_done, e_done);
      chk("R8 irq_rdv", irq_rdv, e_rdv);
      chk("R10 irq_tmo", irq_tmo, e_tmo);
      chk("R9 irq_err", irq_err, e_err);
      chk("R11 irq_any", irq_any, |{e_done, e_rdv, e_tmo, e_err});
      chk("R11 rx_ready", rx_ready, 1'b1);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? 1'b0 : lfsr[0];
  end

  task automatic issue(int c, bit wr, bit [1:0] sz, bit [31:0] a, bit [31:0] d);
    @(negedge clk);
    while (!req_ready[c]) @(negedge clk);
    req_valid[c] = 1; req_write[c] = wr; req_size[c*2 +: 2] = sz;
    req_addr[c*32 +: 32] = a; req_wdata[c*32 +: 32] = d;
    @(negedge clk);
    req_valid[c] = 0;
  endtask

  task automatic drive_rsp(int c, int id, int kind, bit [31:0] d, bit corrupt);
    bit [47:0] b;
    b = {c[1:0], id[2:0], kind[1:0], 9'b0, d};
    rx_data = {b, bcrc({32'h0, b}, 48) ^ {15'h0, corrupt}};
    rx_valid = 1;
    @(negedge clk);
    rx_valid = 0;
  endtask

  // mode 0 good, 1 bad CRC, 2 stale ID, 3 wrong kind; dly extra cycles after waiting starts
  task automatic answer(int c, int mode, bit [31:0] d, int dly);
    int id, kind;
    @(negedge clk);
    while (m_st[c] != 2) @(negedge clk);
    id = m_sid[c]; kind = m_wr[c] ? 2 : 3;
    repeat (dly) @(negedge clk);
    if (mode == 2) id = (id + 5) % 8;
    if (mode == 3) kind = m_wr[c] ? 3 : 2;
    drive_rsp(c, id, kind, d, mode == 1);
  endtask

  task automatic wait_free(int c);
    @(negedge clk);
    while (m_st[c] != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req_ready", req_ready, 4'hF);
    chk("R1 reset tx_valid", tx_valid, 1'b0);
    chk("R1 reset irqs", {irq_done, irq_rdv, irq_tmo, irq_err, irq_any}, '0);
    chk("R1 reset rd_data", rd_data, '0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {req_ready, tx_valid}, {4'hF, 1'b0});

    // R3 R8: basic write and read
    issue(0, 1, 2'd2, 32'h1000_0040, 32'hDEAD_BEEF);
    answer(0, 0, 0, 0);
    issue(1, 0, 2'd0, 32'h2000_0004, 32'hFFFF_FFFF);
    answer(1, 0, 32'hA5A5_5A3C, 1);
    issue(2, 1, 2'd1, 32'h3000_0010, 32'h1234_5678);
    answer(2, 0, 0, 0);
    wait_free(2);

    // R6 R5: lock on a stalled offer, then priority order
    tx_mode = 1;
    issue(2, 1, 2'd0, 32'hC000_0002, 32'h0000_00AB);
    repeat (2) @(negedge clk);
    issue(3, 0, 2'd2, 32'hC000_0003, 0);
    issue(0, 0, 2'd1, 32'hC000_0000, 0);
    repeat (3) @(negedge clk);
    tx_mode = 0;
    answer(2, 0, 0, 0);
    answer(0, 0, 32'h8765_4321, 0);
    answer(3, 0, 32'h0BAD_F00D, 0);
    wait_free(3);

    // R7: ID wrap on channel 0
    for (int i = 0; i < 9; i++) begin
      issue(0, i[0], 2'(i % 3), 32'h5000_0000 + i, 32'h1111_1111 * i);
      answer(0, 0, 32'hCAFE_0000 + i, 0);
    end
    wait_free(0);

    // R9 then R10: bad responses leave channel waiting, then timeout
    cfg_timeout[16 +: 16] = 16'd20;
    issue(1, 0, 2'd2, 32'h6000_0000, 0);
    answer(1, 1, 32'h1, 0);
    answer(1, 2, 32'h2, 0);
    answer(1, 3, 32'h3, 0);
    wait_free(1);
    drive_rsp(3, 0, 2, 0, 0);  // R9: no channel waiting

    // R10: answer on the last allowed edge completes; one later times out
    cfg_timeout[32 +: 16] = 16'd5;
    issue(2, 1, 2'd2, 32'h7000_0000, 32'h55);
    answer(2, 0, 0, 4);
    wait_free(2);
    issue(2, 0, 2'd2, 32'h7000_0004, 0);
    answer(2, 0, 32'h77, 5);
    wait_free(2);

    // R10: zero disables the timeout
    cfg_timeout[48 +: 16] = 16'd0;
    issue(3, 1, 2'd2, 32'h8000_0000, 32'h99);
    repeat (120) @(negedge clk);
    chk("R10 zero timeout still waiting", req_ready[3], 1'b0);
    answer(3, 0, 0, 0);
    wait_free(3);

    // Random back-pressure across all channels
    tx_mode = 2;
    cfg_timeout = {4{16'd60}};
    for (int i = 0; i < 16; i++) begin
      issue(i % 4, (i / 4) % 2 == 0, 2'(i % 4), 32'h9000_0000 + 16 * i, 32'hF0E1_D2C3 ^ i);
      if (i % 4 == 3)
        for (int c = 0; c < 4; c++) answer(c, 0, 32'h3C3C_0000 + c, c);
    end
    for (int c = 0; c < 4; c++) wait_free(c);
    tx_mode = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: requirement all, actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule